// File: doc/BRIEF.md
# Bus-Access Watchdog with System Reset Fan-Out

This block watches the bus of the secondary processor in a two-processor system. Each time that processor completes a read of one particular register address, a timeout counter starts again from zero. If the processor goes a full timeout window without such a read, the block raises a reset pulse of fixed length. The pulse goes to both processors, both video processors and the coin-counter latch of each processor. When the pulse ends, the counter starts again from zero.

The timeout is set from two parameters: the clock frequency in hertz and the window in milliseconds. With the defaults this gives a 1.2 s window. A testbench can set a small frequency so that the window is a few dozen cycles. The power-on reset input is asserted asynchronously and released through a synchronizer. While it is low, and for a short settling period after it is released, the block drives the same reset outputs that an expiry drives.

Top module: `wdg_bus_watchdog`

## Requirements
- R1: All reset outputs (`cpu_rst`, `vid_rst`, `coin_clr`, one bit per processor, active high) carry the same value in every cycle.
- R2: While `rst_n` is low, every reset output is high, starting at once, with no clock edge needed. After `rst_n` rises, the outputs fall on rising edge number HOLD_CYC+SYNC_STAGES.
- R3: A service event is a rising edge at which `sec_cs`=1, `sec_rd`=1 and `sec_addr` equals SVC_ADDR (default 16'h4017). A service event while the outputs are low restarts the count, so the outputs stay low for exactly TIMEOUT_CYC further rising edges.
- R4: Without a service event, the outputs rise on the TIMEOUT_CYC-th rising edge after the edge that lowered them.
- R5: An expiry pulse stays high for exactly HOLD_CYC rising edges. After it, the count restarts from zero.
- R6: These do not service the watchdog: a write (`sec_rd`=0) to SVC_ADDR, a read with `sec_cs`=0, and a read of any other address, such as 16'h4016 or 16'h5017.
- R7: Service events while the outputs are high are ignored, and the pulse length does not change.
- R8: A service event on the very rising edge that would otherwise expire the count (the TIMEOUT_CYC-th edge) wins and prevents the pulse.
- R9: TIMEOUT_CYC equals CLK_HZ*TIMEOUT_MS/1000, rounded down. The default is 1.2 s.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asserted asynchronously |
| sec_addr | input | ADDR_W | Secondary processor address bus |
| sec_rd | input | 1 | 1 = read cycle, 0 = write cycle |
| sec_cs | input | 1 | Bus cycle valid qualifier |
| cpu_rst | output | NUM_CPU | Processor reset, one bit per processor |
| vid_rst | output | NUM_CPU | Video processor reset, one bit per processor |
| coin_clr | output | NUM_CPU | Coin-counter latch clear, one bit per processor |

## Verification
A service event takes effect at the edge where it is presented. The outputs then stay low for exactly TIMEOUT_CYC samples and stay high for exactly HOLD_CYC samples. After `rst_n` is released, the first low appears after HOLD_CYC+SYNC_STAGES-1 high samples. The bench drives each stimulus just after a falling edge and reads the outputs at every falling edge. It counts the low and high runs and compares them with the counts worked out from the parameters. The sweep places a service event at every offset from 1 to TIMEOUT_CYC within a window, so the expected low run is the offset plus TIMEOUT_CYC.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

  typedef enum logic {
    ST_HOLD = 1'b0,
    ST_RUN  = 1'b1
  } wdg_state_e;

  function automatic int cnt_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/wdg_rst_sync.sv
module wdg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/wdg_svc_decode.sv
module wdg_svc_decode #(
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] SVC_ADDR = 'h4017
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              cs_i,
  output logic              svc_o
);

  logic addr_hit;

  always_comb begin
    addr_hit = (addr_i == SVC_ADDR);
    svc_o    = cs_i & rd_i & addr_hit;
  end

endmodule

// File: rtl/wdg_timer.sv
module wdg_timer
  import wdg_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 32,
  parameter int unsigned HOLD_CYC    = 4
) (
  input  logic clk,
  input  logic srst_n,
  input  logic svc_i,
  output logic hold_o
);

  localparam int CW = cnt_width(TIMEOUT_CYC);
  localparam int HW = cnt_width(HOLD_CYC);
  localparam logic [CW-1:0] WD_LAST   = CW'(TIMEOUT_CYC - 1);
  localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_CYC - 1);

  wdg_state_e    state_q, state_d;
  logic [CW-1:0] wd_q, wd_d;
  logic [HW-1:0] hc_q, hc_d;
  logic          wd_en, hc_en, st_en;

  always_comb begin
    state_d = state_q;
    wd_d    = wd_q;
    hc_d    = hc_q;
    wd_en   = 1'b0;
    hc_en   = 1'b0;
    st_en   = 1'b0;
    case (state_q)
      ST_HOLD: begin
        if (hc_q == HOLD_LAST) begin
          state_d = ST_RUN;
          st_en   = 1'b1;
          wd_d    = '0;
          wd_en   = 1'b1;
        end else begin
          hc_d  = hc_q + 1'b1;
          hc_en = 1'b1;
        end
      end
      ST_RUN: begin
        if (svc_i) begin
          wd_d  = '0;
          wd_en = 1'b1;
        end else if (wd_q == WD_LAST) begin
          state_d = ST_HOLD;
          st_en   = 1'b1;
          hc_d    = '0;
          hc_en   = 1'b1;
        end else begin
          wd_d  = wd_q + 1'b1;
          wd_en = 1'b1;
        end
      end
      default: begin
        state_d = ST_HOLD;
        st_en   = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q <= ST_HOLD;
    end else if (st_en) begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      wd_q <= '0;
    end else if (wd_en) begin
      wd_q <= wd_d;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      hc_q <= '0;
    end else if (hc_en) begin
      hc_q <= hc_d;
    end
  end

  assign hold_o = (state_q == ST_HOLD);

endmodule

// File: rtl/wdg_rst_fanout.sv
module wdg_rst_fanout #(
  parameter int NUM_CPU = 2
) (
  input  logic               hold_i,
  output logic [NUM_CPU-1:0] cpu_rst_o,
  output logic [NUM_CPU-1:0] vid_rst_o,
  output logic [NUM_CPU-1:0] coin_clr_o
);

  for (genvar g = 0; g < NUM_CPU; g++) begin : g_side
    assign cpu_rst_o[g]  = hold_i;
    assign vid_rst_o[g]  = hold_i;
    assign coin_clr_o[g] = hold_i;
  end

endmodule

// File: rtl/wdg_bus_watchdog.sv
module wdg_bus_watchdog #(
  parameter int unsigned       CLK_HZ      = 1_789_773,
  parameter int unsigned       TIMEOUT_MS  = 1200,
  parameter int unsigned       HOLD_CYC    = 16,
  parameter int                SYNC_STAGES = 2,
  parameter int                ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] SVC_ADDR    = 'h4017,
  parameter int                NUM_CPU     = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  sec_addr,
  input  logic               sec_rd,
  input  logic               sec_cs,
  output logic [NUM_CPU-1:0] cpu_rst,
  output logic [NUM_CPU-1:0] vid_rst,
  output logic [NUM_CPU-1:0] coin_clr
);

  localparam int unsigned TIMEOUT_CYC =
    32'((64'(CLK_HZ) * 64'(TIMEOUT_MS)) / 64'd1000);

  logic srst_n;
  logic svc;
  logic hold;

  wdg_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  wdg_svc_decode #(
    .ADDR_W   (ADDR_W),
    .SVC_ADDR (SVC_ADDR)
  ) u_dec (
    .addr_i (sec_addr),
    .rd_i   (sec_rd),
    .cs_i   (sec_cs),
    .svc_o  (svc)
  );

  wdg_timer #(
    .TIMEOUT_CYC (TIMEOUT_CYC),
    .HOLD_CYC    (HOLD_CYC)
  ) u_tmr (
    .clk    (clk),
    .srst_n (srst_n),
    .svc_i  (svc),
    .hold_o (hold)
  );

  wdg_rst_fanout #(
    .NUM_CPU (NUM_CPU)
  ) u_fan (
    .hold_i     (hold),
    .cpu_rst_o  (cpu_rst),
    .vid_rst_o  (vid_rst),
    .coin_clr_o (coin_clr)
  );

endmodule

// File: rtl/wdg_bus_watchdog_chk.sv
module wdg_bus_watchdog_chk #(
  parameter int unsigned       CLK_HZ      = 1_789_773,
  parameter int unsigned       TIMEOUT_MS  = 1200,
  parameter int unsigned       HOLD_CYC    = 16,
  parameter int                SYNC_STAGES = 2,
  parameter int                ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] SVC_ADDR    = 'h4017,
  parameter int                NUM_CPU     = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic [ADDR_W-1:0]  sec_addr,
  input logic               sec_rd,
  input logic               sec_cs,
  input logic [NUM_CPU-1:0] cpu_rst,
  input logic [NUM_CPU-1:0] vid_rst,
  input logic [NUM_CPU-1:0] coin_clr
);

  localparam int unsigned T_CYC =
    32'((64'(CLK_HZ) * 64'(TIMEOUT_MS)) / 64'd1000);

  logic        out;
  logic        svc_seen;
  int unsigned lo_q;
  int unsigned hi_q;

  assign out      = cpu_rst[0];
  assign svc_seen = sec_cs && sec_rd && (sec_addr == SVC_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= 0;
    end else if (out || svc_seen) begin
      lo_q <= 0;
    end else begin
      lo_q <= lo_q + 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= 0;
    end else if (!out) begin
      hi_q <= 0;
    end else begin
      hi_q <= hi_q + 1;
    end
  end

  // R1: every reset output carries one common value
  a_r1_outputs_agree: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rst == {NUM_CPU{out}}) && (vid_rst == cpu_rst) && (coin_clr == cpu_rst));

  // R3, R8: a qualifying read while running keeps the outputs low
  a_r3_service_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (!out && svc_seen) |=> !out);

  // R4: the low run never goes past the timeout window
  a_r4_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
    !out |-> (lo_q < T_CYC));

  // R4, R6: the window ends in a pulse unless a qualifying read arrives
  a_r4_expire_on_time: assert property (@(posedge clk) disable iff (!rst_n)
    (!out && !svc_seen && (lo_q == T_CYC - 1)) |=> out);

  // R5, R7: pulse length bounds
  a_r5_hold_max: assert property (@(posedge clk) disable iff (!rst_n)
    out |-> (hi_q <= HOLD_CYC + SYNC_STAGES - 1));

  a_r5_hold_min: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out) |-> (hi_q >= HOLD_CYC));

endmodule

bind wdg_bus_watchdog wdg_bus_watchdog_chk #(
  .CLK_HZ      (CLK_HZ),
  .TIMEOUT_MS  (TIMEOUT_MS),
  .HOLD_CYC    (HOLD_CYC),
  .SYNC_STAGES (SYNC_STAGES),
  .ADDR_W      (ADDR_W),
  .SVC_ADDR    (SVC_ADDR),
  .NUM_CPU     (NUM_CPU)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sec_addr (sec_addr),
  .sec_rd   (sec_rd),
  .sec_cs   (sec_cs),
  .cpu_rst  (cpu_rst),
  .vid_rst  (vid_rst),
  .coin_clr (coin_clr)
);

// File: tb/wdg_bus_watchdog_tb_top.sv
`timescale 1ns/1ps
module wdg_bus_watchdog_tb_top;

  localparam int unsigned CLK_HZ     = 10_000;
  localparam int unsigned TIMEOUT_MS = 3;
  localparam int unsigned HOLD       = 4;
  localparam int          SYNC       = 2;
  localparam int          NCPU       = 2;
  localparam int          T_EXP      = (CLK_HZ * TIMEOUT_MS) / 1000;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [15:0]     sec_addr;
  logic            sec_rd;
  logic            sec_cs;
  logic [NCPU-1:0] cpu_rst, vid_rst, coin_clr;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  wdg_bus_watchdog #(
    .CLK_HZ      (CLK_HZ),
    .TIMEOUT_MS  (TIMEOUT_MS),
    .HOLD_CYC    (HOLD),
    .SYNC_STAGES (SYNC),
    .ADDR_W      (16),
    .SVC_ADDR    (16'h4017),
    .NUM_CPU     (NCPU)
  ) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .sec_addr (sec_addr),
    .sec_rd   (sec_rd),
    .sec_cs   (sec_cs),
    .cpu_rst  (cpu_rst),
    .vid_rst  (vid_rst),
    .coin_clr (coin_clr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit level();
    return cpu_rst[0];
  endfunction

  function automatic bit agree();
    return (cpu_rst == {NCPU{cpu_rst[0]}}) && (vid_rst == cpu_rst) && (coin_clr == cpu_rst);
  endfunction

  task automatic idle();
    sec_cs = 1'b0; sec_rd = 1'b1; sec_addr = 16'h0000;
  endtask

  // kind 0: qualifying read; 1: write; 2: read 4016; 3: read with cs low; 4: read 5017
  task automatic drive(input int kind);
    sec_cs = 1'b1; sec_rd = 1'b1; sec_addr = 16'h4017;
    case (kind)
      1: sec_rd   = 1'b0;
      2: sec_addr = 16'h4016;
      3: sec_cs   = 1'b0;
      4: sec_addr = 16'h5017;
      default: ;
    endcase
  endtask

  // entered at the first low sample of a window
  task automatic window(input int k, input int kind, input bit poke_hold, input string req);
    int  lows  = 1;
    int  highs = 1;
    int  i     = 1;
    int  exp_l = (kind == 0) ? (k + T_EXP) : T_EXP;
    bit  same  = 1'b1;
    while (1) begin
      if (i == k) drive(kind); else idle();
      @(negedge clk);
      i++;
      same &= agree();
      if (level() || lows > 1000) break;
      lows++;
    end
    while (1) begin
      if (poke_hold) drive(0); else idle();
      @(negedge clk);
      same &= agree();
      if (!level() || highs > 1000) break;
      highs++;
    end
    idle();
    chk(lows == exp_l, req, lows, exp_l);
    chk(highs == int'(HOLD), poke_hold ? "R7 pulse length with reads in pulse" : "R5 pulse length", highs, HOLD);
    chk(same, "R1 outputs agree", same, 1);
  endtask

  task automatic release_and_count();
    int highs = 0;
    rst_n = 1'b1;
    while (1) begin
      @(negedge clk);
      if (!level() || highs > 1000) break;
      highs++;
    end
    chk(highs == int'(HOLD) + SYNC - 1, "R2 settle after release", highs, HOLD + SYNC - 1);
  endtask

  initial begin
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(level() && agree(), "R2 asserted in reset", {29'd0, cpu_rst[0], vid_rst[0], coin_clr[0]}, 7);
    release_and_count();

    // R3, R8: service at every offset of the window, last one on the expiry edge
    for (int k = 1; k <= T_EXP; k++) begin
      window(k, 0, 1'b0, (k == T_EXP) ? "R8 service on expiry edge" : "R3 service restart");
    end

    // R4, R9: untouched window length equals CLK_HZ*TIMEOUT_MS/1000
    window(0, 0, 1'b0, "R4 R9 idle window length");

    // R6: non-qualifying cycles at several offsets
    for (int kind = 1; kind <= 4; kind++) begin
      window(1, kind, 1'b0, "R6 non-service cycle ignored");
      window(T_EXP, kind, 1'b0, "R6 non-service cycle ignored at window end");
    end

    // R7: reads during the pulse change nothing
    window(5, 0, 1'b1, "R3 service before pulse");
    window(0, 0, 1'b1, "R4 window before poked pulse");

    // R2: asynchronous reset in the middle of a window
    repeat (7) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(level() && agree(), "R2 async assertion", cpu_rst[0], 1);
    repeat (2) @(negedge clk);
    chk(level(), "R2 held in reset", cpu_rst[0], 1);
    release_and_count();
    window(0, 0, 1'b0, "R4 window after reset");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule